// File: doc/BRIEF.md
# Interrupt Controller Command-Word Decoder

This block is the byte-wide programming interface of one interrupt controller channel. A host writes bytes to one of two addresses, picked by the address bit `a0_i`. The block runs a four-step setup sequence and decodes the run-time command bytes. From these it keeps the channel's configuration: vector base, automatic end-of-interrupt, mask and ready. It passes end-of-interrupt and priority commands to a separate priority unit as one-cycle pulses with their fields.

Reads return the mask, the pending-request bits or the in-service bits. The priority unit supplies the last two, and a run-time command picks between them. A sticky error flag reports three things: a setup the channel cannot honour (single-channel or no fourth step), a missing processor-mode bit, or a read while poll mode is on. Requests from devices are passed to the priority unit only while the channel is ready.

Top module: `pic_cw_decoder`

## Requirements
- R1: After reset these are all zero: ready, error, mask, vector base, automatic EOI, read data, poll, rotate, the setup pulse and the command pulse.
- R2: A write with `a0_i`=0 and data bit 4 set is a setup start. In the next cycle ready and the mask are 0 and the read source is the request bits, and `init_o` pulses for one cycle. If bit 1 is 0 and bit 0 is 1, the start is accepted, the sequence moves to step 2 and the error flag clears.
- R3: A start with bit 1 set or bit 0 clear is rejected. The error flag sets and the sequence stays at step 1, so later `a0_i`=1 writes load the mask.
- R4: At step 2, an `a0_i`=1 write loads the vector base from data bits 7:3. At step 3, an `a0_i`=1 write changes no output.
- R5: At step 4, an `a0_i`=1 write with bit 0 clear sets the error flag, and the channel stays at step 4 and not ready. With bit 0 set, automatic EOI takes bit 1 and ready sets.
- R6: An `a0_i`=1 write outside steps 2 to 4 loads the mask from the data byte.
- R7: While ready, an `a0_i`=0 write with bits 4 and 3 clear pulses `cw2_valid_o` for one cycle. The fields then read: rotate = bit 7, specific = bit 6, EOI = bit 5, level = bits 2:0. `rotate_o` holds bit 7 until the next such write.
- R8: While ready, an `a0_i`=0 write with bit 4 clear and bit 3 set sets `poll_o` to bit 2. If bit 1 is set, bit 0 picks the `a0_i`=0 read source: 1 for in-service, 0 for request.
- R9: Read data is registered. It changes in the cycle after the read strobe: the mask for `a0_i`=1, and `isr_i` or `irr_i` for `a0_i`=0, as picked.
- R10: A read while poll mode is on sets the error flag and returns 0.
- R11: The error flag stays set until the next accepted setup start.
- R12: While not ready, `a0_i`=0 writes with bit 4 clear have no effect and `irq_o` is 0. While ready, `irq_o` follows `irq_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| a0_i | input | 1 | Address bit that selects one of the two addresses |
| wdata_i | input | 8 | Write data |
| irr_i | input | 8 | Pending-request bits from the priority unit |
| isr_i | input | 8 | In-service bits from the priority unit |
| irq_i | input | 8 | Device request lines |
| rdata_o | output | 8 | Registered read data |
| ready_o | output | 1 | Setup is complete |
| vec_base_o | output | 5 | Vector base (upper five bits of the vector) |
| aeoi_o | output | 1 | Automatic end-of-interrupt is enabled |
| mask_o | output | 8 | Interrupt mask |
| init_o | output | 1 | One-cycle pulse after any setup start |
| cw2_valid_o | output | 1 | One-cycle pulse for an EOI or priority command |
| cw2_rotate_o | output | 1 | Rotate field of that command |
| cw2_specific_o | output | 1 | Specific field of that command |
| cw2_eoi_o | output | 1 | EOI field of that command |
| cw2_level_o | output | 3 | Level field of that command |
| rotate_o | output | 1 | Held rotate setting |
| poll_o | output | 1 | Poll mode |
| irq_o | output | 8 | Device requests, gated by ready |
| err_o | output | 1 | Sticky error flag |

## Verification
Every register result (ready, vector base, AEOI, mask, error, poll, read source, rotate and the `init_o` and `cw2_valid_o` pulses) shows at the clock edge that ends the strobe cycle. Read data likewise follows the edge after the read strobe. `irq_o` is the only combinational path, and it follows `ready_o` at once. The bench drives each strobe on a falling edge for one full cycle and samples on the next falling edge. At that point the registered results are due and the pulses are still high. An extra sample inside the strobe cycle shows that read data has not yet moved. One idle cycle later a second sample shows that each pulse lasted a single cycle.

// File: rtl/pic_cw_pkg.sv
package pic_cw_pkg;
  localparam int BYTE_W = 8;
  localparam int LVL_W  = 3;
  localparam int VB_W   = BYTE_W - LVL_W;

  // a0=0 dispatch bits
  localparam int B_START = 4;
  localparam int B_CW3   = 3;
  // setup start
  localparam int B_SNGL  = 1;
  localparam int B_NEED4 = 0;
  // setup step 4
  localparam int B_UPM   = 0;
  localparam int B_AEOI  = 1;
  // command word 2
  localparam int B_ROT   = 7;
  localparam int B_SPEC  = 6;
  localparam int B_EOI   = 5;
  // command word 3
  localparam int B_POLL  = 2;
  localparam int B_RSEL  = 1;
  localparam int B_RISR  = 0;

  typedef enum logic [2:0] {
    STEP_RUN = 3'd0,
    STEP_1   = 3'd1,
    STEP_2   = 3'd2,
    STEP_3   = 3'd3,
    STEP_4   = 3'd4
  } step_e;

  typedef struct packed {
    logic             rotate;
    logic             specific;
    logic             eoi;
    logic [LVL_W-1:0] level;
  } cw2_t;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cw_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int LW = LVL_W,
  localparam int VW = DW - LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          a0_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [VW-1:0] vbase_o,
  output logic          aeoi_o,
  output logic          in_seq_o,
  output logic          start_o,
  output logic          start_ok_o,
  output logic          err_evt_o
);
  step_e         step_q;
  logic          ready_q, aeoi_q;
  logic [VW-1:0] vbase_q;
  logic          wr_cfg, wr_step4;

  assign start_o    = wr_i && !a0_i && wdata_i[B_START];
  assign start_ok_o = start_o && !wdata_i[B_SNGL] && wdata_i[B_NEED4];
  assign in_seq_o   = (step_q == STEP_2) || (step_q == STEP_3) || (step_q == STEP_4);
  assign wr_cfg     = wr_i && a0_i;
  assign wr_step4   = wr_cfg && (step_q == STEP_4);
  assign err_evt_o  = (start_o && !start_ok_o) || (wr_step4 && !wdata_i[B_UPM]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= STEP_RUN;
      ready_q <= 1'b0;
      aeoi_q  <= 1'b0;
      vbase_q <= '0;
    end else if (start_o) begin
      ready_q <= 1'b0;
      step_q  <= start_ok_o ? STEP_2 : STEP_1;
    end else if (wr_cfg) begin
      unique case (step_q)
        STEP_2: begin
          vbase_q <= wdata_i[DW-1:LW];
          step_q  <= STEP_3;
        end
        STEP_3: step_q <= STEP_4;
        STEP_4: begin
          if (wdata_i[B_UPM]) begin
            aeoi_q  <= wdata_i[B_AEOI];
            ready_q <= 1'b1;
            step_q  <= STEP_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  assign ready_o = ready_q;
  assign vbase_o = vbase_q;
  assign aeoi_o  = aeoi_q;

  assert_start_clears_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !ready_q);

  assert_vbase_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && !start_o && step_q == STEP_2) |=> vbase_q == $past(wdata_i[DW-1:LW]));

  assert_ready_needs_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |-> step_q == STEP_RUN);

  assert_step4_reject_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_step4 && !start_o && !wdata_i[B_UPM]) |=> (step_q == STEP_4 && !ready_q));
endmodule

// File: rtl/pic_op_decode.sv
module pic_op_decode
  import pic_cw_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int LW = LVL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          a0_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ready_i,
  input  logic          start_i,
  input  logic          in_seq_i,
  output logic [DW-1:0] mask_o,
  output logic          cw2_valid_o,
  output cw2_t          cw2_o,
  output logic          rotate_o,
  output logic          poll_o,
  output logic          isr_sel_o
);
  logic [DW-1:0] mask_q;
  logic          op_wr, cw2_wr, cw3_wr;
  logic          cw2_valid_q, rotate_q, poll_q, isr_sel_q;
  cw2_t          cw2_q;

  assign op_wr  = wr_i && !a0_i && !wdata_i[B_START] && ready_i;
  assign cw2_wr = op_wr && !wdata_i[B_CW3];
  assign cw3_wr = op_wr && wdata_i[B_CW3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mask_q <= '0;
    else if (start_i)                     mask_q <= '0;
    else if (wr_i && a0_i && !in_seq_i)   mask_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cw2_valid_q <= 1'b0;
      cw2_q       <= '0;
      rotate_q    <= 1'b0;
    end else begin
      cw2_valid_q <= cw2_wr;
      if (cw2_wr) begin
        cw2_q.rotate   <= wdata_i[B_ROT];
        cw2_q.specific <= wdata_i[B_SPEC];
        cw2_q.eoi      <= wdata_i[B_EOI];
        cw2_q.level    <= wdata_i[LW-1:0];
        rotate_q       <= wdata_i[B_ROT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q    <= 1'b0;
      isr_sel_q <= 1'b0;
    end else if (start_i) begin
      isr_sel_q <= 1'b0;
    end else if (cw3_wr) begin
      poll_q <= wdata_i[B_POLL];
      if (wdata_i[B_RSEL]) isr_sel_q <= wdata_i[B_RISR];
    end
  end

  assign mask_o      = mask_q;
  assign cw2_valid_o = cw2_valid_q;
  assign cw2_o       = cw2_q;
  assign rotate_o    = rotate_q;
  assign poll_o      = poll_q;
  assign isr_sel_o   = isr_sel_q;

  assert_cw2_needs_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw2_valid_q |-> $past(ready_i && wr_i && !a0_i));

  assert_not_ready_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_i && !start_i) |=> $stable(isr_sel_q) && $stable(poll_q) && !cw2_valid_q);
endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux
  import pic_cw_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          a0_i,
  input  logic          poll_i,
  input  logic          isr_sel_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] irr_i,
  input  logic [DW-1:0] isr_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_evt_o
);
  logic [DW-1:0] rdata_q, rsel;

  always_comb begin
    if (poll_i)         rsel = '0;
    else if (a0_i)      rsel = mask_i;
    else if (isr_sel_i) rsel = isr_i;
    else                rsel = irr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rsel;
  end

  assign rdata_o   = rdata_q;
  assign err_evt_o = rd_i && poll_i;

  assert_poll_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && poll_i) |=> rdata_q == '0);

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/pic_cw_decoder.sv
module pic_cw_decoder
  import pic_cw_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int LW = LVL_W,
  localparam int VW = DW - LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          a0_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] irr_i,
  input  logic [DW-1:0] isr_i,
  input  logic [DW-1:0] irq_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  output logic [VW-1:0] vec_base_o,
  output logic          aeoi_o,
  output logic [DW-1:0] mask_o,
  output logic          init_o,
  output logic          cw2_valid_o,
  output logic          cw2_rotate_o,
  output logic          cw2_specific_o,
  output logic          cw2_eoi_o,
  output logic [LW-1:0] cw2_level_o,
  output logic          rotate_o,
  output logic          poll_o,
  output logic [DW-1:0] irq_o,
  output logic          err_o
);
  logic ready, in_seq, start, start_ok, init_err, rd_err, isr_sel;
  logic err_q, init_q;
  cw2_t cw2;

  pic_init_seq #(.DW(DW), .LW(LW)) u_init (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .a0_i       (a0_i),
    .wdata_i    (wdata_i),
    .ready_o    (ready),
    .vbase_o    (vec_base_o),
    .aeoi_o     (aeoi_o),
    .in_seq_o   (in_seq),
    .start_o    (start),
    .start_ok_o (start_ok),
    .err_evt_o  (init_err)
  );

  pic_op_decode #(.DW(DW), .LW(LW)) u_op (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .a0_i        (a0_i),
    .wdata_i     (wdata_i),
    .ready_i     (ready),
    .start_i     (start),
    .in_seq_i    (in_seq),
    .mask_o      (mask_o),
    .cw2_valid_o (cw2_valid_o),
    .cw2_o       (cw2),
    .rotate_o    (rotate_o),
    .poll_o      (poll_o),
    .isr_sel_o   (isr_sel)
  );

  pic_read_mux #(.DW(DW)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .a0_i      (a0_i),
    .poll_i    (poll_o),
    .isr_sel_i (isr_sel),
    .mask_i    (mask_o),
    .irr_i     (irr_i),
    .isr_i     (isr_i),
    .rdata_o   (rdata_o),
    .err_evt_o (rd_err)
  );

  // sticky error: cleared only by an accepted start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      init_q <= 1'b0;
    end else begin
      err_q  <= (err_q && !start_ok) || init_err || rd_err;
      init_q <= start;
    end
  end

  assign ready_o        = ready;
  assign init_o         = init_q;
  assign err_o          = err_q;
  assign cw2_rotate_o   = cw2.rotate;
  assign cw2_specific_o = cw2.specific;
  assign cw2_eoi_o      = cw2.eoi;
  assign cw2_level_o    = cw2.level;
  assign irq_o          = ready ? irq_i : '0;

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !start_ok) |=> err_q);

  assert_reject_sets_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !start_ok) |=> err_q);

  assert_accept_clears_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok && !rd_err) |=> !err_q);
endmodule

// File: tb/tb_pic_cw_decoder.sv
`timescale 1ns/1ps
module tb_pic_cw_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, a0 = 1'b0;
  logic [7:0] wdata = '0, irr = '0, isr = '0, irq = '0;
  logic [7:0] rdata, mask, irq_o;
  logic [4:0] vbase;
  logic [2:0] lvl;
  logic       ready, aeoi, init_p, cvalid, crot, cspec, ceoi, rot, poll, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pic_cw_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .a0_i(a0), .wdata_i(wdata),
    .irr_i(irr), .isr_i(isr), .irq_i(irq), .rdata_o(rdata), .ready_o(ready),
    .vec_base_o(vbase), .aeoi_o(aeoi), .mask_o(mask), .init_o(init_p),
    .cw2_valid_o(cvalid), .cw2_rotate_o(crot), .cw2_specific_o(cspec),
    .cw2_eoi_o(ceoi), .cw2_level_o(lvl), .rotate_o(rot), .poll_o(poll),
    .irq_o(irq_o), .err_o(err)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_wr(input logic addr, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; a0 = addr; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_rd(input logic addr);
    @(negedge clk); rd = 1'b1; a0 = addr;
    @(negedge clk); rd = 1'b0;
  endtask

  // {a0, data, ready, err, aeoi, vbase, mask}
  localparam int NV = 13;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 5'd0, 8'h00}, // R2 accepted start
    {1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 5'd4, 8'h00}, // R4 base
    {1'b1, 8'h04, 1'b0, 1'b0, 1'b0, 5'd4, 8'h00}, // R4 step 3 ignored
    {1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 5'd4, 8'h00}, // R5 ready
    {1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 5'd4, 8'h5A}, // R6 mask
    {1'b0, 8'h13, 1'b0, 1'b1, 1'b0, 5'd4, 8'h00}, // R3 single rejected
    {1'b1, 8'h33, 1'b0, 1'b1, 1'b0, 5'd4, 8'h33}, // R3 step 1 loads mask
    {1'b0, 8'h10, 1'b0, 1'b1, 1'b0, 5'd4, 8'h00}, // R3 no step 4 rejected
    {1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 5'd4, 8'h00}, // R2 error clears
    {1'b1, 8'h48, 1'b0, 1'b0, 1'b0, 5'd9, 8'h00}, // R4
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 5'd9, 8'h00}, // R4
    {1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 5'd9, 8'h00}, // R5 mode bit missing
    {1'b1, 8'h03, 1'b1, 1'b1, 1'b1, 5'd9, 8'h00}  // R5 AEOI, R11 err held
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic       t_a0, t_rdy, t_err, t_ae;
    logic [7:0] t_d, t_m;
    logic [4:0] t_vb;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", ready, 0);   check("R1 err", err, 0);
    check("R1 mask", mask, 0);     check("R1 vbase", vbase, 0);
    check("R1 aeoi", aeoi, 0);     check("R1 rdata", rdata, 0);
    check("R1 poll", poll, 0);     check("R1 rotate", rot, 0);
    check("R1 init", init_p, 0);   check("R1 cw2_valid", cvalid, 0);

    for (int i = 0; i < NV; i++) begin
      {t_a0, t_d, t_rdy, t_err, t_ae, t_vb, t_m} = VEC[i];
      do_wr(t_a0, t_d);
      check($sformatf("R2 R3 R4 R5 ready row %0d", i), ready, t_rdy);
      check($sformatf("R3 R5 R11 err row %0d", i), err, t_err);
      check($sformatf("R5 aeoi row %0d", i), aeoi, t_ae);
      check($sformatf("R4 vbase row %0d", i), vbase, t_vb);
      check($sformatf("R6 mask row %0d", i), mask, t_m);
    end

    // R7 command word 2 fields and one-cycle pulse
    do_wr(1'b0, 8'hE5);
    check("R7 valid", cvalid, 1);  check("R7 rotate", crot, 1);
    check("R7 specific", cspec, 1); check("R7 eoi", ceoi, 1);
    check("R7 level", lvl, 5);     check("R7 rotate held", rot, 1);
    @(negedge clk);
    check("R7 pulse width", cvalid, 0);
    check("R7 rotate hold", rot, 1);
    do_wr(1'b0, 8'h20);
    check("R7 valid b", cvalid, 1); check("R7 specific b", cspec, 0);
    check("R7 eoi b", ceoi, 1);    check("R7 level b", lvl, 0);
    check("R7 rotate cleared", rot, 0);

    // R9 reads
    irr = 8'h3C; isr = 8'hC3;
    do_wr(1'b1, 8'hA5);
    do_rd(1'b1);
    check("R9 read mask", rdata, 8'hA5);
    @(negedge clk); rd = 1'b1; a0 = 1'b0;
    #1 check("R9 rdata not yet updated", rdata, 8'hA5);
    @(negedge clk); rd = 1'b0;
    check("R9 read irr", rdata, 8'h3C);
    do_wr(1'b0, 8'h0B);             // R8 select in-service
    do_rd(1'b0);
    check("R8 read isr", rdata, 8'hC3);
    do_wr(1'b0, 8'h08);             // R8 select bit clear: source kept
    do_rd(1'b0);
    check("R8 source kept", rdata, 8'hC3);
    do_wr(1'b0, 8'h0A);
    do_rd(1'b0);
    check("R8 read irr again", rdata, 8'h3C);

    // R12 gating while ready
    irq = 8'h81;
    #1 check("R12 irq pass", irq_o, 8'h81);
    check("R11 err still set", err, 1);

    // R2 restart; R12 while not ready
    do_wr(1'b0, 8'h11);
    check("R2 init pulse", init_p, 1); check("R2 ready low", ready, 0);
    check("R2 err cleared", err, 0);   check("R12 irq blocked", irq_o, 0);
    @(negedge clk);
    check("R2 init pulse width", init_p, 0);
    do_wr(1'b0, 8'h0B);             // would pick in-service if honoured
    check("R12 no cw3 effect", poll, 0);
    do_wr(1'b0, 8'h20);
    check("R12 no cw2 pulse", cvalid, 0);
    do_wr(1'b1, 8'h08); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h01);
    check("R5 ready again", ready, 1);
    check("R5 aeoi off", aeoi, 0);
    do_rd(1'b0);
    check("R12 R2 source is request", rdata, 8'h3C);

    // R10 poll read
    do_wr(1'b0, 8'h0C);
    check("R8 poll on", poll, 1);
    do_rd(1'b0);
    check("R10 rdata zero", rdata, 0);
    check("R10 err set", err, 1);
    do_wr(1'b0, 8'h08);
    check("R8 poll off", poll, 0);
    check("R11 err sticky", err, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule